// File: doc/BRIEF.md
# Clock Power Management Controller

This block decides, cycle by cycle, which clock outputs of a multi-source clock generator may drive their pads and which frequency sources may run. There are four sources by default: source 0 is the reference oscillator and sources 1 to 3 are frequency synthesizers. Each output names the source it is derived from through a configuration field. Two active-low pins steer the block. The first is a combined output-enable/shutdown pin. A configuration bit decides whether a LOW on it only three-states the outputs or also powers down every source. The second is a suspend pin. It removes a configurable set of outputs and a configurable set of sources.

The block refuses to let an output run from a stopped source. When a suspended source still feeds an output that is not in the output suspend mask, the block flags a configuration error and suspends that output as well. The same applies to a source field that names a source that does not exist. After a full shutdown ends, the sources restart at once. The outputs stay dark for a programmable number of reference cycles while the synthesizers relock, and `lock_pending` reports that interval. A disabled output reads LOW on `out_pad`, which stands for the pad pull-down. All interfaces are plain control and status levels, with no stream handshake. The configuration inputs are expected to come from static registers.

Top module: `clkpm_ctrl`

## Requirements
- R1: While the synchronized output-enable/shutdown pin is LOW, every bit of `out_oe` is 0, whatever the configuration.
- R2: With `cfg_shutdown_mode`=1, a LOW on the output-enable/shutdown pin drives every bit of `src_run` to 0.
- R3: With `cfg_shutdown_mode`=0, a LOW on the output-enable/shutdown pin leaves `src_run` unchanged, so it is all ones while suspend is inactive.
- R4: While `suspend_n` is LOW, an output whose bit is set in `cfg_out_susp` has `out_oe`=0, and a source whose bit is set in `cfg_src_susp` has `src_run`=0. While `suspend_n` is HIGH, both masks have no effect.
- R5: Output i takes its source from field `cfg_out_src[i*SRC_W +: SRC_W]`. While suspend is active, an output whose source bit is set in `cfg_src_susp` is disabled even when its own bit in `cfg_out_susp` is clear. An enabled output never has a stopped source.
- R6: `config_error` is 1 exactly when some output has its source bit set in `cfg_src_susp` while its own `cfg_out_susp` bit is clear. The state of the suspend pin does not affect it.
- R7: In shutdown mode, when the pin returns HIGH, `lock_pending` is 1 for exactly `cfg_relock_cycles` cycles. During that interval `src_run` is all ones (unless suspended) and `out_oe` is 0. Outputs enable once it drops. A count of 0 gives no pending interval.
- R8: A new shutdown during the pending interval clears `lock_pending` and stops the sources. The next release restarts the full interval.
- R9: `out_pad[i]` equals `out_clk_raw[i]` when `out_oe[i]`=1 and is 0 otherwise.
- R10: Both pins pass through a two-flop synchronizer, so a pin change reaches `out_oe`/`src_run` on the third rising edge. During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_oe_n | input | 1 | Active-low output-enable / shutdown pin, asynchronous |
| suspend_n | input | 1 | Active-low suspend pin, asynchronous |
| cfg_shutdown_mode | input | 1 | 1: a LOW on the pin also stops all sources; 0: outputs only |
| cfg_relock_cycles | input | CNT_W | Relock interval in clk cycles after a shutdown ends |
| cfg_out_susp | input | N_OUT | Outputs removed while suspend is active |
| cfg_src_susp | input | N_SRC | Sources stopped while suspend is active (bit 0 oscillator) |
| cfg_out_src | input | N_OUT*SRC_W | Per-output source index, output i at bits i*SRC_W |
| out_clk_raw | input | N_OUT | Divided clock per output ahead of the pad gate |
| out_oe | output | N_OUT | Per-output drive enable (0 = high impedance) |
| out_pad | output | N_OUT | Observed pad level, LOW when not driven |
| src_run | output | N_SRC | Per-source run enable |
| lock_pending | output | 1 | Synthesizers relocking after shutdown |
| config_error | output | 1 | Suspend configuration leaves an output on a stopped source |

## Verification
The bench builds the block with four outputs and four sources. With two select bits per output, every source index is legal, and each output-to-source mapping, including all outputs on the oscillator, can be reached from the vector table. The relock counter is 16 bits wide, but the bench loads small counts (0, 5 and 20). At these counts the exact length of the pending window, its abort by a second shutdown and the full restart that follows can all be counted cycle by cycle.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_DOWN   = 2'd1,
    PM_RELOCK = 2'd2
  } pm_state_e;

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // two flops per bit; reset value 0 reads as "pin asserted"
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/clkpm_cfg_check.sv
module clkpm_cfg_check #(
  parameter int N_OUT = 4,
  parameter int N_SRC = 4,
  parameter int SRC_W = 2
) (
  input  logic [N_OUT-1:0]       cfg_out_susp,
  input  logic [N_SRC-1:0]       cfg_src_susp,
  input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
  output logic [N_OUT-1:0]       eff_out_susp,
  output logic [N_OUT-1:0]       out_kill,
  output logic                   cfg_bad
);

  logic [N_OUT-1:0] bad_vec;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [SRC_W-1:0] sel;
    logic             in_range;
    logic             src_off;

    assign sel      = cfg_out_src[g*SRC_W +: SRC_W];
    assign in_range = (int'(sel) < N_SRC);
    assign src_off  = in_range ? cfg_src_susp[sel] : 1'b1;

    // dependent output is suspended along with its source
    assign eff_out_susp[g] = cfg_out_susp[g] | src_off;
    assign out_kill[g]     = ~in_range;
    assign bad_vec[g]      = ~in_range | (src_off & ~cfg_out_susp[g]);
  end

  assign cfg_bad = |bad_vec;

endmodule

// File: rtl/clkpm_relock.sv
module clkpm_relock
  import clkpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             down,
  input  logic [CNT_W-1:0] relock_cycles,
  output logic             block,
  output logic             pending
);

  pm_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PM_RUN: begin
          if (down) state_q <= PM_DOWN;
        end
        PM_DOWN: begin
          if (!down) begin
            if (relock_cycles != '0) begin
              state_q <= PM_RELOCK;
              cnt_q   <= relock_cycles;
            end else begin
              state_q <= PM_RUN;
            end
          end
        end
        PM_RELOCK: begin
          if (down) begin
            state_q <= PM_DOWN;
            cnt_q   <= '0;
          end else begin
            if (cnt_q == CNT_W'(1)) state_q <= PM_RUN;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= PM_RUN;
      endcase
    end
  end

  assign block   = down | (state_q != PM_RUN);
  assign pending = (state_q == PM_RELOCK);

  AST_RELOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && down) |=> (state_q == PM_DOWN)); // R8

  AST_BLOCK_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    down |=> block); // R7

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl #(
  parameter int  N_OUT = 4,
  parameter int  N_SRC = 4,
  parameter int  CNT_W = 16,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shutdown_oe_n,
  input  logic                   suspend_n,
  input  logic                   cfg_shutdown_mode,
  input  logic [CNT_W-1:0]       cfg_relock_cycles,
  input  logic [N_OUT-1:0]       cfg_out_susp,
  input  logic [N_SRC-1:0]       cfg_src_susp,
  input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
  input  logic [N_OUT-1:0]       out_clk_raw,
  output logic [N_OUT-1:0]       out_oe,
  output logic [N_OUT-1:0]       out_pad,
  output logic [N_SRC-1:0]       src_run,
  output logic                   lock_pending,
  output logic                   config_error
);

  logic [1:0]       pins_s;
  logic             sd_s;
  logic             su_s;
  logic             down;
  logic             susp_act;
  logic             block;
  logic [N_OUT-1:0] eff_out_susp;
  logic [N_OUT-1:0] out_kill;
  logic             cfg_bad;
  logic [N_OUT-1:0] oe_d;
  logic [N_SRC-1:0] run_d;
  logic [N_OUT-1:0] oe_q;
  logic [N_SRC-1:0] run_q;
  logic             err_q;

  clkpm_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({suspend_n, shutdown_oe_n}),
    .sync_o  (pins_s)
  );

  assign sd_s     = pins_s[0];
  assign su_s     = pins_s[1];
  assign down     = cfg_shutdown_mode & ~sd_s;
  assign susp_act = ~su_s;

  clkpm_cfg_check #(.N_OUT(N_OUT), .N_SRC(N_SRC), .SRC_W(SRC_W)) u_chk (
    .cfg_out_susp (cfg_out_susp),
    .cfg_src_susp (cfg_src_susp),
    .cfg_out_src  (cfg_out_src),
    .eff_out_susp (eff_out_susp),
    .out_kill     (out_kill),
    .cfg_bad      (cfg_bad)
  );

  clkpm_relock #(.CNT_W(CNT_W)) u_relock (
    .clk           (clk),
    .rst_n         (rst_n),
    .down          (down),
    .relock_cycles (cfg_relock_cycles),
    .block         (block),
    .pending       (lock_pending)
  );

  assign oe_d  = {N_OUT{sd_s & ~block}}
               & ~({N_OUT{susp_act}} & eff_out_susp)
               & ~out_kill;
  assign run_d = {N_SRC{~down}} & ~({N_SRC{susp_act}} & cfg_src_susp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '0;
      run_q <= '0;
      err_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      run_q <= run_d;
      err_q <= cfg_bad;
    end
  end

  assign out_oe       = oe_q;
  assign src_run      = run_q;
  assign config_error = err_q;
  assign out_pad      = oe_q & out_clk_raw;

  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_s |=> (out_oe == '0)); // R1

  AST_DOWN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    down |=> (src_run == '0)); // R2

  AST_OE_MODE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_shutdown_mode && su_s) |=> (&src_run)); // R3

  AST_PENDING_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pending |-> (out_oe == '0)); // R7

  for (genvar g = 0; g < N_OUT; g++) begin : g_dep
    AST_SRC_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      out_oe[g] |-> src_run[$past(cfg_out_src[g*SRC_W +: SRC_W])]); // R5
  end

endmodule

// File: tb/clkpm_ctrl_tb.sv
module clkpm_ctrl_tb;

  localparam int N_OUT = 4;
  localparam int N_SRC = 4;
  localparam int CNT_W = 16;
  localparam int NV    = 12;

  // {mode, sd_n, su_n, out_susp[4], src_susp[4], out_src[8], exp_oe[4], exp_run[4], exp_err}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,4'b0000,4'b0000,8'hE5,4'b1111,4'b1111,1'b0},
    {1'b0,1'b0,1'b1,4'b0000,4'b0000,8'hE5,4'b0000,4'b1111,1'b0},
    {1'b1,1'b0,1'b1,4'b0000,4'b0000,8'hE5,4'b0000,4'b0000,1'b0},
    {1'b1,1'b1,1'b1,4'b0000,4'b0000,8'hE5,4'b1111,4'b1111,1'b0},
    {1'b0,1'b1,1'b0,4'b0101,4'b0000,8'hE5,4'b1010,4'b1111,1'b0},
    {1'b0,1'b1,1'b0,4'b0010,4'b0100,8'hE5,4'b1001,4'b1011,1'b1},
    {1'b0,1'b1,1'b1,4'b0010,4'b0100,8'hE5,4'b1111,4'b1111,1'b1},
    {1'b0,1'b1,1'b0,4'b0011,4'b0010,8'hE5,4'b1100,4'b1101,1'b0},
    {1'b1,1'b0,1'b0,4'b0011,4'b0010,8'hE5,4'b0000,4'b0000,1'b0},
    {1'b0,1'b1,1'b0,4'b0000,4'b0001,8'hE5,4'b1111,4'b1110,1'b0},
    {1'b0,1'b1,1'b0,4'b0000,4'b1000,8'hE5,4'b0111,4'b0111,1'b1},
    {1'b0,1'b1,1'b0,4'b0000,4'b0001,8'h00,4'b0000,4'b1110,1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             shutdown_oe_n;
  logic             suspend_n;
  logic             cfg_shutdown_mode;
  logic [CNT_W-1:0] cfg_relock_cycles;
  logic [N_OUT-1:0] cfg_out_susp;
  logic [N_SRC-1:0] cfg_src_susp;
  logic [7:0]       cfg_out_src;
  logic [N_OUT-1:0] out_clk_raw;
  logic [N_OUT-1:0] out_oe;
  logic [N_OUT-1:0] out_pad;
  logic [N_SRC-1:0] src_run;
  logic             lock_pending;
  logic             config_error;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  clkpm_ctrl #(.N_OUT(N_OUT), .N_SRC(N_SRC), .CNT_W(CNT_W)) u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .shutdown_oe_n     (shutdown_oe_n),
    .suspend_n         (suspend_n),
    .cfg_shutdown_mode (cfg_shutdown_mode),
    .cfg_relock_cycles (cfg_relock_cycles),
    .cfg_out_susp      (cfg_out_susp),
    .cfg_src_susp      (cfg_src_susp),
    .cfg_out_src       (cfg_out_src),
    .out_clk_raw       (out_clk_raw),
    .out_oe            (out_oe),
    .out_pad           (out_pad),
    .src_run           (src_run),
    .lock_pending      (lock_pending),
    .config_error      (config_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    shutdown_oe_n = 1'b1;
    suspend_n = 1'b1;
    cfg_shutdown_mode = 1'b0;
    cfg_relock_cycles = '0;
    cfg_out_susp = '0;
    cfg_src_susp = '0;
    cfg_out_src = 8'hE5;
    out_clk_raw = '0;

    // R10 reset state
    wait_n(3);
    chk("R10 reset oe", 32'(out_oe), 32'h0);
    chk("R10 reset run", 32'(src_run), 32'h0);
    chk("R10 reset pending", 32'(lock_pending), 32'h0);
    chk("R10 reset err", 32'(config_error), 32'h0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R10 after reset oe", 32'(out_oe), 32'hF);

    // table walk (R1..R6)
    for (int v = 0; v < NV; v++) begin
      cfg_shutdown_mode = VEC[v][27];
      shutdown_oe_n     = VEC[v][26];
      suspend_n         = VEC[v][25];
      cfg_out_susp      = VEC[v][24:21];
      cfg_src_susp      = VEC[v][20:17];
      cfg_out_src       = VEC[v][16:9];
      wait_n(6);
      chk($sformatf("R1/R4/R5 vec%0d oe", v), 32'(out_oe), 32'(VEC[v][8:5]));
      chk($sformatf("R2/R3/R4 vec%0d run", v), 32'(src_run), 32'(VEC[v][4:1]));
      chk($sformatf("R6 vec%0d err", v), 32'(config_error), 32'(VEC[v][0]));
    end

    // return to a clean state
    cfg_shutdown_mode = 1'b0; shutdown_oe_n = 1'b1; suspend_n = 1'b1;
    cfg_out_susp = '0; cfg_src_susp = '0; cfg_out_src = 8'hE5;
    wait_n(6);

    // R10 latency: change visible on the third edge
    shutdown_oe_n = 1'b0;
    wait_n(2);
    chk("R10 latency old", 32'(out_oe), 32'hF);
    wait_n(1);
    chk("R10 latency new", 32'(out_oe), 32'h0);
    shutdown_oe_n = 1'b1;
    wait_n(6);

    // R9 pad gating
    out_clk_raw = 4'b1010;
    #1;
    chk("R9 pad follows", 32'(out_pad), 32'hA);
    shutdown_oe_n = 1'b0;
    out_clk_raw = 4'b1111;
    wait_n(5);
    chk("R9 pad low", 32'(out_pad), 32'h0);
    shutdown_oe_n = 1'b1;
    wait_n(6);

    // R7 no pending in output-enable mode
    shutdown_oe_n = 1'b0;
    cfg_relock_cycles = 16'd5;
    wait_n(6);
    shutdown_oe_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lock_pending) cnt++;
    end
    chk("R7 oe mode no pending", 32'(cnt), 32'd0);

    // R7 relock window of exactly 5 cycles
    cfg_shutdown_mode = 1'b1;
    shutdown_oe_n = 1'b0;
    wait_n(6);
    shutdown_oe_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lock_pending) begin
        cnt++;
        chk("R7 dark while pending", 32'(out_oe), 32'h0);
        chk("R7 sources run while pending", 32'(src_run), 32'hF);
      end
    end
    chk("R7 pending length", 32'(cnt), 32'd5);
    chk("R7 outputs after relock", 32'(out_oe), 32'hF);

    // R7 zero count
    cfg_relock_cycles = 16'd0;
    shutdown_oe_n = 1'b0;
    wait_n(6);
    shutdown_oe_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (lock_pending) cnt++;
    end
    chk("R7 zero count", 32'(cnt), 32'd0);
    chk("R7 zero count oe", 32'(out_oe), 32'hF);

    // R8 abort and restart
    cfg_relock_cycles = 16'd20;
    shutdown_oe_n = 1'b0;
    wait_n(6);
    shutdown_oe_n = 1'b1;
    wait_n(5);
    chk("R8 pending mid", 32'(lock_pending), 32'h1);
    shutdown_oe_n = 1'b0;
    wait_n(4);
    chk("R8 pending aborted", 32'(lock_pending), 32'h0);
    chk("R8 sources stopped", 32'(src_run), 32'h0);
    chk("R8 outputs off", 32'(out_oe), 32'h0);
    shutdown_oe_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (lock_pending) cnt++;
    end
    chk("R8 full restart", 32'(cnt), 32'd20);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule